// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the register storage of a 32-bit processor core that runs in one of seven operating modes. Software always sees sixteen general registers (index 13 serves as stack pointer, 14 as link register, 15 as program counter) plus one saved status word. Behind those names the block keeps 37 physical 32-bit words: 31 general registers, the current status word and five saved status words. The current mode picks which physical word each index reaches, so an exception mode gets private copies of some registers without software saving them.

Two combinational read ports and one synchronous write port serve the general registers. A separate port writes the saved status word of the current mode. The current status word is held here as four 8-bit fields. A write names the fields it updates through a per-field mask, and the write is filtered by privilege: unprivileged code can only change the condition flags. The mode lives in the low five bits of that word, so a mode change is a privileged write of the control field. Everything around the block (instruction decode, exception entry, flag generation) drives these ports.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3 (supervisor mode, both interrupt mask bits 7 and 6 set), and every general and saved register reads zero.
- R2: In user mode and system mode, indices 0 to 15 reach the same sixteen common registers; a value written in system mode is read back in user mode.
- R3: In fast interrupt mode, indices 8 to 14 reach seven registers private to that mode; indices 0 to 7 and 15 reach the common registers.
- R4: In interrupt, supervisor, abort and undefined mode, indices 13 and 14 reach a pair private to that mode; every other index reaches the common registers.
- R5: The two read ports are combinational and independent, and a register write becomes visible on the read ports after the next rising clock edge.
- R6: A status write updates field k (bits 8k+7 to 8k) only when mask bit k is set: mask bit 3 flags [31:24], bit 2 status [23:16], bit 1 extension [15:8], bit 0 control [7:0]. In any mode other than user, all selected fields are written.
- R7: In user mode, a status write changes only the flags field; the status, extension and control fields, the mode included, keep their values.
- R8: A privileged control-field write with a legal mode value changes the mode at the next edge; a general-register write in the same cycle goes to the register selected by the old mode.
- R9: A control-field write whose bits 4:0 are not a legal mode leaves bits 4:0 unchanged while bits 7:5 still take the written value.
- R10: Fast interrupt, interrupt, supervisor, abort and undefined mode each own one saved status register, which the saved read output shows in that mode; in user and system mode the saved read output is zero and saved-status writes have no effect.
- R11: Mode values in bits 4:0 are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111, and the mode output shows them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 4 | Architectural index for read port A |
| rdDataA | output | 32 | Read data of port A |
| rdAddrB | input | 4 | Architectural index for read port B |
| rdDataB | output | 32 | Read data of port B |
| wrEn | input | 1 | General-register write enable |
| wrAddr | input | 4 | Architectural index to write |
| wrData | input | 32 | General-register write data |
| psrWrEn | input | 1 | Status word write enable |
| psrWrMask | input | 4 | Per-field write mask, bit k selects bits 8k+7:8k |
| psrWrData | input | 32 | Status word write data |
| savedWrEn | input | 1 | Saved status write enable for the current mode |
| savedWrData | input | 32 | Saved status write data |
| statusOut | output | 32 | Current status word |
| savedOut | output | 32 | Saved status of the current mode, zero in user and system mode |
| modeOut | output | 5 | Current mode value |

## Verification
The case that needs care is a general-register write landing in the same cycle as a mode change, since the bank selection changes at exactly the edge that commits the write. The bench raises both strobes together, a write to the link register and a control-field write that moves from supervisor to abort mode, then reads the link register in abort mode, where it must still be zero, and again after returning to supervisor mode, where it must hold the written value. Field filtering across the user and privileged split and the illegal-mode write are judged by comparing the whole status word with values worked out by hand.

// File: rtl/mrf_pkg.sv
package mrf_pkg;

  localparam int XLEN        = 32;
  localparam int FIELD_W     = 8;
  localparam int NUM_FIELDS  = XLEN / FIELD_W;
  localparam int FLAGS_FIELD = NUM_FIELDS - 1;
  localparam int MODE_W      = 5;

  localparam int ARCH_REGS   = 16;
  localparam int IDX_W       = $clog2(ARCH_REGS);
  localparam int FIQ_BANKED  = 7;
  localparam int EXC_MODES   = 4;
  localparam int EXC_BANKED  = 2;
  localparam int FIQ_BASE    = ARCH_REGS;
  localparam int EXC_BASE    = FIQ_BASE + FIQ_BANKED;
  localparam int PHYS_GPRS   = EXC_BASE + EXC_MODES * EXC_BANKED;
  localparam int PHYS_W      = $clog2(PHYS_GPRS);
  localparam int SAVED_REGS  = EXC_MODES + 1;
  localparam int SAVED_W     = $clog2(SAVED_REGS);

  localparam logic [IDX_W-1:0] IDX_SP = IDX_W'(13);
  localparam logic [IDX_W-1:0] IDX_LR = IDX_W'(14);
  localparam logic [IDX_W-1:0] FIQ_LO = IDX_W'(8);

  localparam logic [XLEN-1:0] STATUS_RESET = XLEN'(32'h0000_00D3);

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } cpuMode_e;

  // Strobes from control to storage
  typedef struct packed {
    logic               gprWe;
    logic [PHYS_W-1:0]  gprSel;
    logic [PHYS_W-1:0]  rdSelA;
    logic [PHYS_W-1:0]  rdSelB;
    logic               savedWe;
    logic [SAVED_W-1:0] savedSel;
    logic               savedVisible;
  } rfStrobes_t;

  function automatic logic isValidMode(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic isPrivileged(input logic [MODE_W-1:0] m);
    return m != MODE_USR;
  endfunction

  // Modes other than fast interrupt that bank only r13/r14
  function automatic logic isExcMode(input logic [MODE_W-1:0] m);
    return (m == MODE_IRQ) || (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND);
  endfunction

  function automatic logic hasSaved(input logic [MODE_W-1:0] m);
    return (m == MODE_FIQ) || isExcMode(m);
  endfunction

  function automatic int excSlot(input logic [MODE_W-1:0] m);
    case (m)
      MODE_IRQ: return 0;
      MODE_SVC: return 1;
      MODE_ABT: return 2;
      default:  return 3;
    endcase
  endfunction

  function automatic logic [SAVED_W-1:0] savedSlot(input logic [MODE_W-1:0] m);
    if (m == MODE_FIQ) return '0;
    return SAVED_W'(excSlot(m) + 1);
  endfunction

  function automatic logic [PHYS_W-1:0] physIndex(input logic [MODE_W-1:0] m,
                                                   input logic [IDX_W-1:0]  idx);
    logic [PHYS_W-1:0] r;
    r = PHYS_W'(idx);
    if (m == MODE_FIQ) begin
      if (idx >= FIQ_LO && idx <= IDX_LR)
        r = PHYS_W'(FIQ_BASE + int'(idx) - int'(FIQ_LO));
    end else if (isExcMode(m)) begin
      if (idx == IDX_SP || idx == IDX_LR)
        r = PHYS_W'(EXC_BASE + EXC_BANKED * excSlot(m) + int'(idx) - int'(IDX_SP));
    end
    return r;
  endfunction

endpackage

// File: rtl/mrf_ctrl.sv
module mrf_ctrl
  import mrf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [IDX_W-1:0]      rdAddrA,
  input  logic [IDX_W-1:0]      rdAddrB,
  input  logic                  wrEn,
  input  logic [IDX_W-1:0]      wrAddr,
  input  logic                  psrWrEn,
  input  logic [NUM_FIELDS-1:0] psrWrMask,
  input  logic [XLEN-1:0]       psrWrData,
  input  logic                  savedWrEn,
  output rfStrobes_t            strb,
  output logic [XLEN-1:0]       statusQ
);

  logic [XLEN-1:0]   statusD;
  logic [MODE_W-1:0] curMode;
  logic              curPriv;

  assign curMode = statusQ[MODE_W-1:0];
  assign curPriv = isPrivileged(curMode);

  // Field-filtered next status word
  always_comb begin
    statusD = statusQ;
    if (psrWrEn) begin
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (psrWrMask[f] && (curPriv || f == FLAGS_FIELD))
          statusD[f*FIELD_W +: FIELD_W] = psrWrData[f*FIELD_W +: FIELD_W];
      end
      if (!isValidMode(statusD[MODE_W-1:0]))
        statusD[MODE_W-1:0] = statusQ[MODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= STATUS_RESET;
    else       statusQ <= statusD;
  end

  // Index mapping uses the mode in force before the edge
  always_comb begin
    strb.gprWe        = wrEn;
    strb.gprSel       = physIndex(curMode, wrAddr);
    strb.rdSelA       = physIndex(curMode, rdAddrA);
    strb.rdSelB       = physIndex(curMode, rdAddrB);
    strb.savedVisible = hasSaved(curMode);
    strb.savedWe      = savedWrEn && hasSaved(curMode);
    strb.savedSel     = savedSlot(curMode);
  end

  // R7
  user_flags_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psrWrEn && curMode == MODE_USR) |=> $stable(statusQ[XLEN-FIELD_W-1:0]));

  // R6
  priv_flags_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psrWrEn && curPriv && psrWrMask[FLAGS_FIELD])
      |=> statusQ[XLEN-1 -: FIELD_W] == $past(psrWrData[XLEN-1 -: FIELD_W]));

  // R8
  mode_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (psrWrEn && curPriv && psrWrMask[0] && isValidMode(psrWrData[MODE_W-1:0]))
      |=> statusQ[MODE_W-1:0] == $past(psrWrData[MODE_W-1:0]));

  // R9
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    isValidMode(statusQ[MODE_W-1:0]));

  // R10
  saved_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (curMode == MODE_USR || curMode == MODE_SYS) |-> !strb.savedWe);

endmodule

// File: rtl/mrf_datapath.sv
module mrf_datapath
  import mrf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  rfStrobes_t      strb,
  input  logic [XLEN-1:0] wrData,
  input  logic [XLEN-1:0] savedWrData,
  output logic [XLEN-1:0] rdDataA,
  output logic [XLEN-1:0] rdDataB,
  output logic [XLEN-1:0] savedRd
);

  logic [XLEN-1:0] gprArr   [PHYS_GPRS];
  logic [XLEN-1:0] savedArr [SAVED_REGS];

  for (genvar g = 0; g < PHYS_GPRS; g++) begin : g_gpr
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                         q <= '0;
      else if (strb.gprWe && strb.gprSel == PHYS_W'(g))  q <= wrData;
    end
    assign gprArr[g] = q;
  end

  for (genvar s = 0; s < SAVED_REGS; s++) begin : g_saved
    logic [XLEN-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                            q <= '0;
      else if (strb.savedWe && strb.savedSel == SAVED_W'(s)) q <= savedWrData;
    end
    assign savedArr[s] = q;
  end

  assign rdDataA = gprArr[strb.rdSelA];
  assign rdDataB = gprArr[strb.rdSelB];
  assign savedRd = strb.savedVisible ? savedArr[strb.savedSel] : '0;

  // R5
  gpr_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.gprWe |=> gprArr[$past(strb.gprSel)] == $past(wrData));

  // R10
  saved_write_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.savedWe |=> savedArr[$past(strb.savedSel)] == $past(savedWrData));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import mrf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  rdAddrA,
  output logic [31:0] rdDataA,
  input  logic [3:0]  rdAddrB,
  output logic [31:0] rdDataB,
  input  logic        wrEn,
  input  logic [3:0]  wrAddr,
  input  logic [31:0] wrData,
  input  logic        psrWrEn,
  input  logic [3:0]  psrWrMask,
  input  logic [31:0] psrWrData,
  input  logic        savedWrEn,
  input  logic [31:0] savedWrData,
  output logic [31:0] statusOut,
  output logic [31:0] savedOut,
  output logic [4:0]  modeOut
);

  rfStrobes_t strb;

  mrf_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rdAddrA   (rdAddrA),
    .rdAddrB   (rdAddrB),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .psrWrEn   (psrWrEn),
    .psrWrMask (psrWrMask),
    .psrWrData (psrWrData),
    .savedWrEn (savedWrEn),
    .strb      (strb),
    .statusQ   (statusOut)
  );

  mrf_datapath i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .savedWrData (savedWrData),
    .rdDataA     (rdDataA),
    .rdDataB     (rdDataB),
    .savedRd     (savedOut)
  );

  assign modeOut = statusOut[MODE_W-1:0];

endmodule

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0, psrWrMask = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, psrWrData = '0, savedWrData = '0;
  logic [31:0] statusOut, savedOut;
  logic [4:0]  modeOut;
  logic        wrEn = 1'b0, psrWrEn = 1'b0, savedWrEn = 1'b0;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  banked_regfile i_banked_regfile (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .psrWrEn(psrWrEn), .psrWrMask(psrWrMask), .psrWrData(psrWrData),
    .savedWrEn(savedWrEn), .savedWrData(savedWrData),
    .statusOut(statusOut), .savedOut(savedOut), .modeOut(modeOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic readA(input logic [3:0] a, output logic [31:0] v);
    rdAddrA = a; #0.5; v = rdDataA;
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wrAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic writePsr(input logic [3:0] m, input logic [31:0] d);
    @(negedge clk); psrWrMask = m; psrWrData = d; psrWrEn = 1'b1;
    @(negedge clk); psrWrEn = 1'b0;
  endtask

  task automatic writeSaved(input logic [31:0] d);
    @(negedge clk); savedWrData = d; savedWrEn = 1'b1;
    @(negedge clk); savedWrEn = 1'b0;
  endtask

  task automatic setMode(input logic [4:0] m);
    writePsr(4'b0001, {24'h0, 3'b110, m});
  endtask

  task automatic tReset();
    logic [31:0] v;
    check("R1 status after reset", statusOut, 32'h0000_00D3);
    check("R1 saved after reset", savedOut, 32'h0);
    check("R11 reset mode supervisor", {27'h0, modeOut}, 32'h13);
    for (int i = 0; i < 16; i++) begin
      readA(4'(i), v);
      check("R1 register zero after reset", v, 32'h0);
    end
  endtask

  task automatic tReadPorts();
    logic [31:0] v;
    writeReg(4'd3, 32'h3333_3333);
    writeReg(4'd13, 32'h5A5A_0013);
    rdAddrA = 4'd3; rdAddrB = 4'd3; #0.5;
    check("R5 port A index 3", rdDataA, 32'h3333_3333);
    check("R5 port B same index", rdDataB, 32'h3333_3333);
    rdAddrA = 4'd13; #0.5;
    check("R5 port A index 13", rdDataA, 32'h5A5A_0013);
    check("R5 port B independent", rdDataB, 32'h3333_3333);
    // write is not visible before its edge
    @(negedge clk); wrAddr = 4'd3; wrData = 32'hCAFE_0003; wrEn = 1'b1;
    readA(4'd3, v);
    check("R5 old value before edge", v, 32'h3333_3333);
    @(negedge clk); wrEn = 1'b0;
    readA(4'd3, v);
    check("R5 new value after edge", v, 32'hCAFE_0003);
  endtask

  task automatic tFiq();
    logic [31:0] v;
    setMode(5'b10001);
    check("R11 fast interrupt mode value", {27'h0, modeOut}, 32'h11);
    readA(4'd13, v); check("R3 fiq r13 private", v, 32'h0);
    readA(4'd3, v);  check("R3 fiq r3 common", v, 32'hCAFE_0003);
    for (int i = 8; i < 15; i++) writeReg(4'(i), 32'hF000_0000 + 32'(i));
    writeReg(4'd15, 32'h1515_1515);
    readA(4'd8, v);  check("R3 fiq r8 written", v, 32'hF000_0008);
    readA(4'd14, v); check("R3 fiq r14 written", v, 32'hF000_000E);
    check("R10 fiq saved starts zero", savedOut, 32'h0);
    writeSaved(32'hF1F1_F1F1);
    check("R10 fiq saved written", savedOut, 32'hF1F1_F1F1);
  endtask

  task automatic tIrq();
    logic [31:0] v;
    setMode(5'b10010);
    readA(4'd8, v);  check("R4 irq r8 common", v, 32'h0);
    readA(4'd13, v); check("R4 irq r13 private", v, 32'h0);
    readA(4'd15, v); check("R3 r15 common across modes", v, 32'h1515_1515);
    check("R10 irq saved own", savedOut, 32'h0);
    writeReg(4'd13, 32'h0000_1113);
    readA(4'd13, v); check("R4 irq r13 written", v, 32'h0000_1113);
  endtask

  task automatic tSystem();
    logic [31:0] v;
    setMode(5'b11111);
    check("R11 system mode value", {27'h0, modeOut}, 32'h1F);
    check("R10 system saved reads zero", savedOut, 32'h0);
    writeSaved(32'hDEAD_BEEF);
    check("R10 system saved write ignored", savedOut, 32'h0);
    readA(4'd13, v); check("R2 system r13 common", v, 32'h0);
    writeReg(4'd13, 32'h5050_0013);
    writeReg(4'd8, 32'h0000_0088);
    setMode(5'b10011);
    readA(4'd13, v); check("R4 svc r13 kept", v, 32'h5A5A_0013);
    readA(4'd8, v);  check("R3 common r8 from system", v, 32'h0000_0088);
    check("R10 svc saved untouched", savedOut, 32'h0);
  endtask

  task automatic tFields();
    writePsr(4'b1010, 32'hAABB_CCDD);
    check("R6 flags and extension only", statusOut, 32'hAA00_CCD3);
    writePsr(4'b0101, 32'h00EE_00D3);
    check("R6 status and control", statusOut, 32'hAAEE_CCD3);
  endtask

  task automatic tBadMode();
    writePsr(4'b0001, 32'h0000_0025);
    check("R9 illegal mode keeps bits 4:0", statusOut, 32'hAAEE_CC33);
    writePsr(4'b0001, 32'h0000_00D3);
    check("R9 restore control", statusOut, 32'hAAEE_CCD3);
  endtask

  task automatic tSameCycle();
    logic [31:0] v;
    @(negedge clk);
    wrAddr = 4'd14; wrData = 32'h7777_0014; wrEn = 1'b1;
    psrWrMask = 4'b0001; psrWrData = 32'h0000_00D7; psrWrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0; psrWrEn = 1'b0;
    check("R8 mode abort after edge", {27'h0, modeOut}, 32'h17);
    readA(4'd14, v); check("R8 abort r14 untouched", v, 32'h0);
    writeSaved(32'h0000_00AB);
    check("R10 abort saved written", savedOut, 32'h0000_00AB);
    setMode(5'b11011);
    check("R11 undefined mode value", {27'h0, modeOut}, 32'h1B);
    readA(4'd13, v); check("R4 und r13 private", v, 32'h0);
    check("R10 und saved own", savedOut, 32'h0);
    setMode(5'b10011);
    readA(4'd14, v); check("R8 write went to old mode", v, 32'h7777_0014);
  endtask

  task automatic tUser();
    logic [31:0] v;
    writePsr(4'b0001, 32'h0000_00D0);
    check("R11 user mode value", statusOut, 32'hAAEE_CCD0);
    writePsr(4'b1111, 32'h1122_3344);
    check("R7 user writes flags only", statusOut, 32'h11EE_CCD0);
    check("R7 user mode unchanged", {27'h0, modeOut}, 32'h10);
    check("R10 user saved reads zero", savedOut, 32'h0);
    readA(4'd13, v); check("R2 user sees system r13", v, 32'h5050_0013);
    readA(4'd8, v);  check("R2 user r8 common", v, 32'h0000_0088);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tReadPorts();
    tFiq();
    tIrq();
    tSystem();
    tFields();
    tBadMode();
    tSameCycle();
    tUser();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule